// File: doc/BRIEF.md
# Dataway Command Frame Assembler

This block sits behind a serial line demodulator. The demodulator delivers each frame on a one-cycle strobe, together with its payload width bit, its payload and its parity bit. The block collects the frames that make up one dataway command and checks the format and range of each field. At the end of a command it emits a decoded record: crate, slot (N), subaddress (A), function (F), optional write data and optional block-transfer setup values. It also reports each aborted command.

A command always opens with a crate frame, followed by a slot/subaddress/function frame. A write function then takes one 24-bit data frame. The setup command N=24, A=15, F=16 instead takes a block-transfer NAF frame followed by a count frame. The sequence is run by a five-state machine:

- States: `ST_CRATE` waits for the crate frame, `ST_NAF` for the command word, `ST_WDATA` for write data, `ST_BT_NAF` for the block-transfer target, and `ST_BT_CNT` for the count frame.
- Transitions: a good crate frame moves from `ST_CRATE` to `ST_NAF`. From `ST_NAF`, a setup command moves to `ST_BT_NAF`, a write moves to `ST_WDATA`, and any other valid frame finishes back to `ST_CRATE`. `ST_BT_NAF` moves to `ST_BT_CNT`. `ST_WDATA` and `ST_BT_CNT` finish to `ST_CRATE`. A bad frame in any state other than `ST_CRATE` aborts to `ST_CRATE`.

Top module: `cmd_frame_parser`

## Requirements
- R1: During and right after reset the block waits for a crate frame. `cmd_done` and `proto_err` are low, and every record output is zero.
- R2: In `ST_CRATE`, a 16-bit frame (`frm_wide`=0) with good parity is accepted, and its payload bits 15..8 become `cmd_crate`. All other record fields are cleared. A crate frame with bad parity or with `frm_wide`=1 is dropped silently: no error is flagged and the block keeps waiting.
- R3: Parity is odd. The ones among the used payload bits (15..0 when narrow, 23..0 when wide) plus `frm_parity` must total an odd number. A parity mismatch on any frame after the crate frame pulses `proto_err`, abandons the command without `cmd_done`, and returns to `ST_CRATE`.
- R4: The command word and both block-transfer frames must be narrow, and the write-data frame must be wide. A width mismatch aborts the command exactly as in R3.
- R5: The command word carries N in bits 15..11, a separator in bit 10, A in bits 9..6, a separator in bit 5 and F in bits 4..0. These appear on `cmd_n`, `cmd_a` and `cmd_f`.
- R6: `cmd_naf_ok` is 1 only when both separators are 1 and N is 24 or less. When it is 0, the command ends after the command word, with no write or setup flag set.
- R7: A valid command word with F from 16 to 23 (other than the setup code) is a write. The block waits for a wide frame, then reports `cmd_is_write`=1 and that frame's 24 bits on `cmd_wdata`.
- R8: A valid command word with N=24, A=15, F=16 is a block-transfer setup. It reports `cmd_is_bt`=1 and `cmd_is_write`=0, and it completes only after two further narrow frames.
- R9: The block-transfer NAF frame uses the same field positions as R5. `bt_ok` is 1 only when both separators are 0, N is 23 or less and F is 7 or less. The count frame is consumed whatever the value of `bt_ok`.
- R10: The count frame's bits 15..8 appear on `bt_wcnt_m1` and its bits 7..0 on `bt_noq_m1`, both unchanged (each value is the count minus one).
- R11: `cmd_done` and `proto_err` are single-cycle pulses, never high together. Each rises in the cycle after the frame strobe that completes or aborts a command. The record fields of a completed command are valid while `cmd_done` is high. Fields that do not belong to the command's kind read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a frame is present |
| frm_wide | input | 1 | Payload width bit: 0 = 16-bit, 1 = 24-bit |
| frm_payload | input | 24 | Frame payload; upper 8 bits unused when narrow |
| frm_parity | input | 1 | Frame parity bit (odd) |
| cmd_done | output | 1 | Pulse: a command completed |
| proto_err | output | 1 | Pulse: a command was aborted |
| cmd_crate | output | 8 | Crate address |
| cmd_n | output | 5 | Slot |
| cmd_a | output | 4 | Subaddress |
| cmd_f | output | 5 | Function |
| cmd_naf_ok | output | 1 | Command word accepted |
| cmd_is_write | output | 1 | Command carried write data |
| cmd_wdata | output | 24 | Write data |
| cmd_is_bt | output | 1 | Command is a block-transfer setup |
| bt_n | output | 5 | Block-transfer target slot |
| bt_a | output | 4 | Block-transfer subaddress |
| bt_f | output | 5 | Block-transfer function |
| bt_ok | output | 1 | Block-transfer NAF accepted |
| bt_wcnt_m1 | output | 8 | Word count minus one |
| bt_noq_m1 | output | 8 | Maximum no-Q count minus one |

## Verification
The assertions check on every cycle that completion and abort are exclusive, that both pulses land in `ST_CRATE`, and that each follows a frame strobe. They also check that any reported write carries a function in the write range, and that an accepted command word or block-transfer NAF respects its N and F limits. Whether the right number of frames was consumed, whether fields were taken from the right bit positions, and whether bad crate frames were dropped silently can only be shown by the bench's scenarios. The bench compares those against its reference model.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    parameter int NARROW_W = 16;
    parameter int WIDE_W   = 24;
    parameter int CRATE_W  = 8;
    parameter int N_W      = 5;
    parameter int A_W      = 4;
    parameter int F_W      = 5;
    parameter int CNT_W    = 8;

    typedef enum logic [2:0] {
        ST_CRATE  = 3'd0,
        ST_NAF    = 3'd1,
        ST_WDATA  = 3'd2,
        ST_BT_NAF = 3'd3,
        ST_BT_CNT = 3'd4
    } cfp_state_e;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic           sep_hi;
        logic [A_W-1:0] a;
        logic           sep_lo;
        logic [F_W-1:0] f;
    } naf_word_t;
endpackage

// File: rtl/cfp_frame_check.sv
module cfp_frame_check
    import cfp_pkg::*;
(
    input  logic [WIDE_W-1:0] payload,
    input  logic              wide,
    input  logic              parity,
    input  logic              expect_wide,
    output logic              frame_ok
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0] used_bits;
    logic              parity_ok;

    always_comb begin
        used_bits = wide ? payload : {{PAD_W{1'b0}}, payload[NARROW_W-1:0]};
        parity_ok = ^{used_bits, parity};
        frame_ok  = parity_ok && (wide == expect_wide);
    end
endmodule

// File: rtl/cfp_naf_split.sv
module cfp_naf_split
    import cfp_pkg::*;
#(
    parameter int MAX_N    = 24,
    parameter int BT_MAX_N = 23,
    parameter int BT_MAX_F = 7
) (
    input  logic [NARROW_W-1:0] word,
    output naf_word_t           fields,
    output logic                normal_ok,
    output logic                bt_fmt_ok
);
    localparam logic [N_W-1:0] MAX_N_L    = N_W'(MAX_N);
    localparam logic [N_W-1:0] BT_MAX_N_L = N_W'(BT_MAX_N);
    localparam logic [F_W-1:0] BT_MAX_F_L = F_W'(BT_MAX_F);

    always_comb begin
        fields    = naf_word_t'(word);
        normal_ok = fields.sep_hi && fields.sep_lo && (fields.n <= MAX_N_L);
        bt_fmt_ok = !fields.sep_hi && !fields.sep_lo &&
                    (fields.n <= BT_MAX_N_L) && (fields.f <= BT_MAX_F_L);
    end
endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cfp_pkg::*;
#(
    parameter int MAX_N      = 24,
    parameter int BT_MAX_N   = 23,
    parameter int BT_MAX_F   = 7,
    parameter int WRITE_F_LO = 16,
    parameter int WRITE_F_HI = 23,
    parameter int SETUP_N    = 24,
    parameter int SETUP_A    = 15,
    parameter int SETUP_F    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic                frm_wide,
    input  logic [WIDE_W-1:0]   frm_payload,
    input  logic                frm_parity,
    output logic                cmd_done,
    output logic                proto_err,
    output logic [CRATE_W-1:0]  cmd_crate,
    output logic [N_W-1:0]      cmd_n,
    output logic [A_W-1:0]      cmd_a,
    output logic [F_W-1:0]      cmd_f,
    output logic                cmd_naf_ok,
    output logic                cmd_is_write,
    output logic [WIDE_W-1:0]   cmd_wdata,
    output logic                cmd_is_bt,
    output logic [N_W-1:0]      bt_n,
    output logic [A_W-1:0]      bt_a,
    output logic [F_W-1:0]      bt_f,
    output logic                bt_ok,
    output logic [CNT_W-1:0]    bt_wcnt_m1,
    output logic [CNT_W-1:0]    bt_noq_m1
);
    localparam logic [N_W-1:0] SETUP_N_L  = N_W'(SETUP_N);
    localparam logic [A_W-1:0] SETUP_A_L  = A_W'(SETUP_A);
    localparam logic [F_W-1:0] SETUP_F_L  = F_W'(SETUP_F);
    localparam logic [F_W-1:0] WR_LO_L    = F_W'(WRITE_F_LO);
    localparam logic [F_W-1:0] WR_HI_L    = F_W'(WRITE_F_HI);
    localparam logic [N_W-1:0] MAX_N_L    = N_W'(MAX_N);
    localparam logic [N_W-1:0] BT_MAX_N_L = N_W'(BT_MAX_N);
    localparam logic [F_W-1:0] BT_MAX_F_L = F_W'(BT_MAX_F);
    localparam int             CRATE_LSB  = NARROW_W - CRATE_W;

    cfp_state_e st_q, st_nx;
    logic       frame_ok, expect_wide;
    naf_word_t  naf;
    logic       naf_fmt_ok, bt_fmt_ok;
    logic       is_setup, is_wr;
    logic       finish, abort;

    assign expect_wide = (st_q == ST_WDATA);

    cfp_frame_check u_check (
        .payload     (frm_payload),
        .wide        (frm_wide),
        .parity      (frm_parity),
        .expect_wide (expect_wide),
        .frame_ok    (frame_ok)
    );

    cfp_naf_split #(
        .MAX_N    (MAX_N),
        .BT_MAX_N (BT_MAX_N),
        .BT_MAX_F (BT_MAX_F)
    ) u_split (
        .word      (frm_payload[NARROW_W-1:0]),
        .fields    (naf),
        .normal_ok (naf_fmt_ok),
        .bt_fmt_ok (bt_fmt_ok)
    );

    always_comb begin
        is_setup = naf_fmt_ok && naf.n == SETUP_N_L && naf.a == SETUP_A_L && naf.f == SETUP_F_L;
        is_wr    = naf_fmt_ok && !is_setup && naf.f >= WR_LO_L && naf.f <= WR_HI_L;
    end

    // next-state and completion decode
    always_comb begin
        st_nx  = st_q;
        finish = 1'b0;
        abort  = 1'b0;
        unique case (st_q)
            ST_CRATE: begin
                if (frm_valid && frame_ok) st_nx = ST_NAF;
            end
            ST_NAF: begin
                if (frm_valid) begin
                    if (!frame_ok)     abort  = 1'b1;
                    else if (is_setup) st_nx  = ST_BT_NAF;
                    else if (is_wr)    st_nx  = ST_WDATA;
                    else               finish = 1'b1;
                end
            end
            ST_WDATA: begin
                if (frm_valid) begin
                    if (frame_ok) finish = 1'b1;
                    else          abort  = 1'b1;
                end
            end
            ST_BT_NAF: begin
                if (frm_valid) begin
                    if (frame_ok) st_nx = ST_BT_CNT;
                    else          abort = 1'b1;
                end
            end
            ST_BT_CNT: begin
                if (frm_valid) begin
                    if (frame_ok) finish = 1'b1;
                    else          abort  = 1'b1;
                end
            end
            default: st_nx = ST_CRATE;
        endcase
        if (finish || abort) st_nx = ST_CRATE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CRATE;
        else        st_q <= st_nx;
    end

    // output and record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_done     <= 1'b0;
            proto_err    <= 1'b0;
            cmd_crate    <= '0;
            cmd_n        <= '0;
            cmd_a        <= '0;
            cmd_f        <= '0;
            cmd_naf_ok   <= 1'b0;
            cmd_is_write <= 1'b0;
            cmd_wdata    <= '0;
            cmd_is_bt    <= 1'b0;
            bt_n         <= '0;
            bt_a         <= '0;
            bt_f         <= '0;
            bt_ok        <= 1'b0;
            bt_wcnt_m1   <= '0;
            bt_noq_m1    <= '0;
        end else begin
            cmd_done  <= finish;
            proto_err <= abort;
            if (frm_valid && frame_ok) begin
                unique case (st_q)
                    ST_CRATE: begin
                        cmd_crate    <= frm_payload[NARROW_W-1:CRATE_LSB];
                        cmd_n        <= '0;
                        cmd_a        <= '0;
                        cmd_f        <= '0;
                        cmd_naf_ok   <= 1'b0;
                        cmd_is_write <= 1'b0;
                        cmd_wdata    <= '0;
                        cmd_is_bt    <= 1'b0;
                        bt_n         <= '0;
                        bt_a         <= '0;
                        bt_f         <= '0;
                        bt_ok        <= 1'b0;
                        bt_wcnt_m1   <= '0;
                        bt_noq_m1    <= '0;
                    end
                    ST_NAF: begin
                        cmd_n        <= naf.n;
                        cmd_a        <= naf.a;
                        cmd_f        <= naf.f;
                        cmd_naf_ok   <= naf_fmt_ok;
                        cmd_is_write <= is_wr;
                        cmd_is_bt    <= is_setup;
                    end
                    ST_WDATA: cmd_wdata <= frm_payload;
                    ST_BT_NAF: begin
                        bt_n  <= naf.n;
                        bt_a  <= naf.a;
                        bt_f  <= naf.f;
                        bt_ok <= bt_fmt_ok;
                    end
                    ST_BT_CNT: begin
                        bt_wcnt_m1 <= frm_payload[NARROW_W-1:CNT_W];
                        bt_noq_m1  <= frm_payload[CNT_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // assertions
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_done && proto_err)); // R11
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_done || proto_err) |-> $past(frm_valid)); // R11
    AST_ABORT_TO_CRATE: assert property (@(posedge clk) disable iff (!rst_n) proto_err |-> st_q == ST_CRATE); // R3
    AST_DONE_TO_CRATE: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |-> st_q == ST_CRATE); // R11
    AST_NAF_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_done && cmd_naf_ok) |-> cmd_n <= MAX_N_L); // R6
    AST_WRITE_F_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_done && cmd_is_write) |-> (cmd_f >= WR_LO_L && cmd_f <= WR_HI_L)); // R7
    AST_SETUP_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cmd_done |-> !(cmd_is_bt && cmd_is_write)); // R8
    AST_BT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_done && bt_ok) |-> (cmd_is_bt && bt_n <= BT_MAX_N_L && bt_f <= BT_MAX_F_L)); // R9
endmodule

// File: tb/test_cmd_frame_parser.sv
module test_cmd_frame_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic        frm_wide = 1'b0;
    logic [23:0] frm_payload = '0;
    logic        frm_parity = 1'b0;
    logic        cmd_done, proto_err, cmd_naf_ok, cmd_is_write, cmd_is_bt, bt_ok;
    logic [7:0]  cmd_crate, bt_wcnt_m1, bt_noq_m1;
    logic [4:0]  cmd_n, cmd_f, bt_n, bt_f;
    logic [3:0]  cmd_a, bt_a;
    logic [23:0] cmd_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmd_frame_parser i_cmd_frame_parser (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_wide(frm_wide),
        .frm_payload(frm_payload), .frm_parity(frm_parity),
        .cmd_done(cmd_done), .proto_err(proto_err), .cmd_crate(cmd_crate),
        .cmd_n(cmd_n), .cmd_a(cmd_a), .cmd_f(cmd_f), .cmd_naf_ok(cmd_naf_ok),
        .cmd_is_write(cmd_is_write), .cmd_wdata(cmd_wdata), .cmd_is_bt(cmd_is_bt),
        .bt_n(bt_n), .bt_a(bt_a), .bt_f(bt_f), .bt_ok(bt_ok),
        .bt_wcnt_m1(bt_wcnt_m1), .bt_noq_m1(bt_noq_m1)
    );

    // reference model
    int stage = 0;
    int e_done = 0, e_err = 0;
    int m_crate, m_n, m_a, m_f, m_nok, m_wr, m_wdata, m_bt, m_btn, m_bta, m_btf, m_btok, m_wc, m_nq;

    task automatic clear_rec();
        m_n = 0; m_a = 0; m_f = 0; m_nok = 0; m_wr = 0; m_wdata = 0;
        m_bt = 0; m_btn = 0; m_bta = 0; m_btf = 0; m_btok = 0; m_wc = 0; m_nq = 0;
    endtask

    always @(posedge clk) begin
        int ones, want_wide, good, p;
        e_done = 0;
        e_err  = 0;
        if (!rst_n) begin
            stage = 0; m_crate = 0; clear_rec();
        end else if (frm_valid) begin
            ones = frm_wide ? $countones(frm_payload) : $countones(frm_payload[15:0]);
            want_wide = (stage == 2) ? 1 : 0;
            good = (((ones + frm_parity) % 2) == 1 && frm_wide == want_wide) ? 1 : 0;
            p = int'(frm_payload);
            if (stage != 0 && !good) begin
                e_err = 1; stage = 0;
            end else if (good) begin
                case (stage)
                    0: begin clear_rec(); m_crate = (p >> 8) & 255; stage = 1; end
                    1: begin
                        m_n = (p >> 11) & 31; m_a = (p >> 6) & 15; m_f = p & 31;
                        m_nok = (((p >> 10) & 1) == 1 && ((p >> 5) & 1) == 1 && m_n <= 24) ? 1 : 0;
                        m_bt = (m_nok == 1 && m_n == 24 && m_a == 15 && m_f == 16) ? 1 : 0;
                        m_wr = (m_nok == 1 && m_bt == 0 && m_f >= 16 && m_f <= 23) ? 1 : 0;
                        if (m_bt == 1)      stage = 3;
                        else if (m_wr == 1) stage = 2;
                        else begin e_done = 1; stage = 0; end
                    end
                    2: begin m_wdata = p; e_done = 1; stage = 0; end
                    3: begin
                        m_btn = (p >> 11) & 31; m_bta = (p >> 6) & 15; m_btf = p & 31;
                        m_btok = (((p >> 10) & 1) == 0 && ((p >> 5) & 1) == 0 && m_btn <= 23 && m_btf <= 7) ? 1 : 0;
                        stage = 4;
                    end
                    default: begin m_wc = (p >> 8) & 255; m_nq = p & 255; e_done = 1; stage = 0; end
                endcase
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        chk("R11", "cmd_done", int'(cmd_done), e_done);
        chk("R3/R4", "proto_err", int'(proto_err), e_err);
        if (e_done == 1) begin
            chk("R2", "crate", int'(cmd_crate), m_crate);
            chk("R5", "n", int'(cmd_n), m_n);
            chk("R5", "a", int'(cmd_a), m_a);
            chk("R5", "f", int'(cmd_f), m_f);
            chk("R6", "naf_ok", int'(cmd_naf_ok), m_nok);
            chk("R7", "is_write", int'(cmd_is_write), m_wr);
            chk("R7", "wdata", int'(cmd_wdata), m_wdata);
            chk("R8", "is_bt", int'(cmd_is_bt), m_bt);
            chk("R9", "bt_n", int'(bt_n), m_btn);
            chk("R9", "bt_a", int'(bt_a), m_bta);
            chk("R9", "bt_f", int'(bt_f), m_btf);
            chk("R9", "bt_ok", int'(bt_ok), m_btok);
            chk("R10", "wcnt", int'(bt_wcnt_m1), m_wc);
            chk("R10", "noq", int'(bt_noq_m1), m_nq);
        end
    end

    task automatic send(input logic wide, input logic [23:0] pl, input logic bad_par);
        logic par;
        par = wide ? ~(^pl) : ~(^pl[15:0]);
        @(negedge clk);
        frm_valid = 1'b1; frm_wide = wide; frm_payload = pl; frm_parity = par ^ bad_par;
        @(negedge clk);
        frm_valid = 1'b0; frm_payload = '0;
        @(negedge clk);
    endtask

    function automatic logic [23:0] naf_word(input int n, input int s1, input int a, input int s0, input int f);
        logic [15:0] w;
        w = {n[4:0], s1[0], a[3:0], s0[0], f[4:0]};
        return {8'h00, w};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "done in reset", int'(cmd_done), 0);
        chk("R1", "err in reset", int'(proto_err), 0);
        chk("R1", "crate in reset", int'(cmd_crate), 0);
        chk("R1", "wdata in reset", int'(cmd_wdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", int'(cmd_done), 0);

        // R2: bad crate frames dropped silently
        send(1'b0, 24'h00_3A00, 1'b1);
        send(1'b1, 24'h00_3A00, 1'b0);
        // R5: plain read
        send(1'b0, 24'h00_3A00, 1'b0);
        send(1'b0, naf_word(5, 1, 2, 1, 0), 1'b0);
        // R6: boundary N=24 ok, N=25 rejected, bad separator rejected
        send(1'b0, 24'h00_0100, 1'b0);
        send(1'b0, naf_word(24, 1, 0, 1, 0), 1'b0);
        send(1'b0, 24'h00_0200, 1'b0);
        send(1'b0, naf_word(25, 1, 1, 1, 17), 1'b0);
        send(1'b0, 24'h00_0300, 1'b0);
        send(1'b0, naf_word(3, 0, 1, 1, 16), 1'b0);
        // R7: writes at F=16 and F=23, F=24 is not a write
        send(1'b0, 24'h00_0400, 1'b0);
        send(1'b0, naf_word(3, 1, 7, 1, 16), 1'b0);
        send(1'b1, 24'hA5_C3_96, 1'b0);
        send(1'b0, 24'h00_0500, 1'b0);
        send(1'b0, naf_word(23, 1, 0, 1, 23), 1'b0);
        send(1'b1, 24'hFF_FF_FF, 1'b0);
        send(1'b0, 24'h00_0600, 1'b0);
        send(1'b0, naf_word(1, 1, 0, 1, 24), 1'b0);
        // R4: narrow frame where write data expected
        send(1'b0, 24'h00_0700, 1'b0);
        send(1'b0, naf_word(2, 1, 0, 1, 18), 1'b0);
        send(1'b0, 24'h00_1234, 1'b0);
        // R3: parity error on command word, then wide command word
        send(1'b0, 24'h00_0800, 1'b0);
        send(1'b0, naf_word(2, 1, 0, 1, 0), 1'b1);
        send(1'b0, 24'h00_0900, 1'b0);
        send(1'b1, naf_word(2, 1, 0, 1, 0), 1'b0);
        // R8 R9 R10: good setup
        send(1'b0, 24'h00_0A00, 1'b0);
        send(1'b0, naf_word(24, 1, 15, 1, 16), 1'b0);
        send(1'b0, naf_word(23, 0, 9, 0, 7), 1'b0);
        send(1'b0, 24'h00_FF00, 1'b0);
        // R9: F=8 rejected, separator set rejected, count still consumed
        send(1'b0, 24'h00_0B00, 1'b0);
        send(1'b0, naf_word(24, 1, 15, 1, 16), 1'b0);
        send(1'b0, naf_word(4, 0, 1, 0, 8), 1'b0);
        send(1'b0, 24'h00_12_34, 1'b0);
        send(1'b0, 24'h00_0C00, 1'b0);
        send(1'b0, naf_word(0, 1, 0, 0, 0), 1'b0);
        send(1'b0, 24'h00_0C00, 1'b0);
        send(1'b0, naf_word(24, 1, 15, 1, 16), 1'b0);
        send(1'b0, naf_word(0, 0, 0, 1, 0), 1'b0);
        send(1'b0, 24'h00_00FF, 1'b0);
        // R4: wide count frame aborts setup
        send(1'b0, 24'h00_0D00, 1'b0);
        send(1'b0, naf_word(24, 1, 15, 1, 16), 1'b0);
        send(1'b0, naf_word(1, 0, 0, 0, 1), 1'b0);
        send(1'b1, 24'h00_0101, 1'b0);
        // back-to-back strobes: R11
        @(negedge clk);
        frm_valid = 1'b1; frm_wide = 1'b0; frm_payload = 24'h00_0E00; frm_parity = ~(^16'h0E00);
        @(negedge clk);
        frm_payload = naf_word(6, 1, 3, 1, 1); frm_parity = ~(^naf_word(6, 1, 3, 1, 1));
        @(negedge clk);
        frm_valid = 1'b0;
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule